// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block turns the synchronised input vector of a small general-purpose I/O port into interrupt status. Each line has its own detector that can watch for a high level, a low level, a rising edge, a falling edge, or any edge. Edge hits are held in a sticky status bit until software clears them. Level hits are not stored: the status bit shows the live pin level and drops as soon as the pin leaves the active level.

Software sets the detectors up and services them through a byte-wide register bus. Writes take effect on the clock edge, and reads return data combinationally. A per-line enable gates the raw status into a masked status. One combined interrupt output is high whenever any masked bit is set. The bus offsets are fixed because driver code decodes them.

Top module: `gpio_irq_detect`

## Requirements
- R1: After a synchronous active-low reset, every configuration, enable and status register reads zero and `irq_out` is low.
- R2: The configuration registers are read/write, and bit i of each controls line i. They sit at these offsets: line-mode select at 0x404, any-edge select at 0x408, polarity select at 0x40C and enable at 0x410.
- R3: When a mode-select bit is 1, that line is level-sensed. Its raw status equals 1 exactly when the pin matches the polarity bit (1 means active high, 0 means active low). It follows the pin with no latching, and clear writes do not affect it.
- R4: When a mode-select bit is 0 and its any-edge bit is 0, the line is edge-sensed. A polarity bit of 1 sets its raw status on a 0-to-1 change of the sampled pin, and a polarity bit of 0 sets it on a 1-to-0 change. The bit is readable after the clock edge that samples the new pin value, and it stays set.
- R5: In edge mode, an any-edge bit of 1 sets the raw status on either transition, whatever the value of the polarity bit.
- R6: Raw status reads at 0x414. Masked status reads at 0x418 and equals raw status AND enable. `irq_out` is high exactly when the masked status is non-zero.
- R7: Writing 1 to bit i at 0x41C clears line i's latched edge status. Writing 0 changes nothing. Reading 0x41C returns zero.
- R8: If an edge hit and a clear of the same line fall on the same clock edge, the status bit remains set.
- R9: Changing the configuration never creates an edge hit by itself. The first sample taken after reset is never treated as an edge.
- R10: Writes to the status offsets 0x414 and 0x418, or to an unmapped offset, change no register. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_LINES | Synchronised port input vector |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Read data, combinational |
| irq_out | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check four things. The combined interrupt must agree with raw status and enable. A level-sensed status bit must track its pin. An edge status bit may only appear after a real pin transition. A clear with no competing transition must empty the bit, and reads of the clear offset must return zero. The bench covers what needs a sequence of accesses: every mode on every line, readback of the registers, that writes to read-only and unmapped offsets are ignored, the same-edge race between clear and hit, and the absence of false hits when the configuration is rewritten while pins sit still.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register offsets and the register-select type used by the
// GPIO interrupt detector. Offsets are byte addresses on the register bus.
package gpio_irq_pkg;

    localparam logic [11:0] OFF_MODE   = 12'h404;
    localparam logic [11:0] OFF_ANYEDG = 12'h408;
    localparam logic [11:0] OFF_POL    = 12'h40C;
    localparam logic [11:0] OFF_ENABLE = 12'h410;
    localparam logic [11:0] OFF_RAW    = 12'h414;
    localparam logic [11:0] OFF_MASKED = 12'h418;
    localparam logic [11:0] OFF_CLEAR  = 12'h41C;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_MODE,
        RS_ANYEDG,
        RS_POL,
        RS_ENABLE,
        RS_RAW,
        RS_MASKED,
        RS_CLEAR
    } reg_sel_e;

endpackage

// File: rtl/gpio_irq_cfg.sv
// Module: gpio_irq_cfg
// Decodes the register bus address. Holds the four read/write configuration
// registers and produces a one-cycle clear pulse vector.
// Assumes: ADDR_W >= 12. Writes take effect on the clock edge. Writes to
// status or unmapped offsets are dropped.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output reg_sel_e             reg_sel,
    output logic [NUM_LINES-1:0] mode_q,
    output logic [NUM_LINES-1:0] anyedg_q,
    output logic [NUM_LINES-1:0] pol_q,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] clr_pulse
);

    logic wr_en;

    // Address decode: map the offset to a register select
    always_comb begin
        if      (bus_addr == ADDR_W'(OFF_MODE))   reg_sel = RS_MODE;
        else if (bus_addr == ADDR_W'(OFF_ANYEDG)) reg_sel = RS_ANYEDG;
        else if (bus_addr == ADDR_W'(OFF_POL))    reg_sel = RS_POL;
        else if (bus_addr == ADDR_W'(OFF_ENABLE)) reg_sel = RS_ENABLE;
        else if (bus_addr == ADDR_W'(OFF_RAW))    reg_sel = RS_RAW;
        else if (bus_addr == ADDR_W'(OFF_MASKED)) reg_sel = RS_MASKED;
        else if (bus_addr == ADDR_W'(OFF_CLEAR))  reg_sel = RS_CLEAR;
        else                                      reg_sel = RS_NONE;
    end

    assign wr_en = bus_sel && bus_wr;

    // Clear pulse: write data of a clear access, zero otherwise
    always_comb begin
        clr_pulse = '0;
        if (wr_en && reg_sel == RS_CLEAR) clr_pulse = bus_wdata;
    end

    // Configuration registers: reset to zero, load on a matching write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            anyedg_q <= '0;
            pol_q    <= '0;
            en_q     <= '0;
        end else if (wr_en) begin
            case (reg_sel)
                RS_MODE:   mode_q   <= bus_wdata;
                RS_ANYEDG: anyedg_q <= bus_wdata;
                RS_POL:    pol_q    <= bus_wdata;
                RS_ENABLE: en_q     <= bus_wdata;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_line.sv
// Module: gpio_irq_line
// Detector for one line. It compares the pin with its previous sample to find
// edges, latches edge hits until they are cleared, and passes the level
// comparison straight through in level mode.
// Assumes: pin is already synchronised. The first sample after reset only
// arms the detector.
module gpio_irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic level_mode,
    input  logic any_edge,
    input  logic polarity,
    input  logic clr,
    output logic raw
);

    logic prev_q;
    logic armed_q;
    logic edge_q;
    logic rise;
    logic fall;
    logic hit;

    // Edge classification against the previous sample
    always_comb begin
        rise = pin & ~prev_q;
        fall = ~pin & prev_q;
        if (any_edge) hit = armed_q & (rise | fall);
        else          hit = armed_q & (polarity ? rise : fall);
    end

    // Sample history and sticky edge status; a hit outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
            edge_q  <= 1'b0;
        end else begin
            prev_q  <= pin;
            armed_q <= 1'b1;
            if (level_mode) edge_q <= 1'b0;
            else if (hit)   edge_q <= 1'b1;
            else if (clr)   edge_q <= 1'b0;
        end
    end

    // Raw status: live level match or latched edge
    assign raw = level_mode ? ~(pin ^ polarity) : edge_q;

endmodule

// File: rtl/gpio_irq_rdmux.sv
// Module: gpio_irq_rdmux
// Forms the masked status and the combined interrupt, and returns read data
// for the selected register.
// Assumes: reads are combinational. The clear and unmapped offsets return zero.
module gpio_irq_rdmux
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 bus_sel,
    input  reg_sel_e             reg_sel,
    input  logic [NUM_LINES-1:0] mode_q,
    input  logic [NUM_LINES-1:0] anyedg_q,
    input  logic [NUM_LINES-1:0] pol_q,
    input  logic [NUM_LINES-1:0] en_q,
    input  logic [NUM_LINES-1:0] raw_st,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 irq_out
);

    logic [NUM_LINES-1:0] masked;

    assign masked  = raw_st & en_q;
    assign irq_out = |masked;

    // Read data select
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (reg_sel)
                RS_MODE:   bus_rdata = mode_q;
                RS_ANYEDG: bus_rdata = anyedg_q;
                RS_POL:    bus_rdata = pol_q;
                RS_ENABLE: bus_rdata = en_q;
                RS_RAW:    bus_rdata = raw_st;
                RS_MASKED: bus_rdata = masked;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect (top)
// Per-line interrupt detection for a GPIO port. It is built from a register
// block, one detector per line and a read/combine stage.
// Assumes: pin_in is synchronised to clk. Reset is synchronous and active low.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_in,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 irq_out
);

    reg_sel_e             reg_sel;
    logic [NUM_LINES-1:0] mode_q;
    logic [NUM_LINES-1:0] anyedg_q;
    logic [NUM_LINES-1:0] pol_q;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] clr_pulse;
    logic [NUM_LINES-1:0] raw_st;

    gpio_irq_cfg #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .reg_sel   (reg_sel),
        .mode_q    (mode_q),
        .anyedg_q  (anyedg_q),
        .pol_q     (pol_q),
        .en_q      (en_q),
        .clr_pulse (clr_pulse)
    );

    // One detector per line
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        gpio_irq_line u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (pin_in[i]),
            .level_mode (mode_q[i]),
            .any_edge   (anyedg_q[i]),
            .polarity   (pol_q[i]),
            .clr        (clr_pulse[i]),
            .raw        (raw_st[i])
        );
    end

    gpio_irq_rdmux #(
        .NUM_LINES (NUM_LINES)
    ) u_rdmux (
        .bus_sel   (bus_sel),
        .reg_sel   (reg_sel),
        .mode_q    (mode_q),
        .anyedg_q  (anyedg_q),
        .pol_q     (pol_q),
        .en_q      (en_q),
        .raw_st    (raw_st),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
// Module: gpio_irq_detect_chk
// Property checker bound into gpio_irq_detect. It watches ports and internal
// register outputs, and keeps a small cycle counter so that the properties
// never look back past reset.
module gpio_irq_detect_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_LINES-1:0] bus_rdata,
    input logic [NUM_LINES-1:0] pin_in,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] mode_q,
    input logic [NUM_LINES-1:0] pol_q,
    input logic [NUM_LINES-1:0] en_q,
    input logic [NUM_LINES-1:0] raw_st,
    input logic [NUM_LINES-1:0] clr_pulse
);

    logic [1:0] cyc;
    logic       just_out;

    // Cycles since reset, saturating; marks the first cycle out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc      <= '0;
            just_out <= 1'b1;
        end else begin
            if (cyc != 2'd3) cyc <= cyc + 2'd1;
            just_out <= 1'b0;
        end
    end

    // R1: no status or interrupt on the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (just_out && cyc == 2'd0) |-> (!irq_out && raw_st == '0));

    // R6: combined interrupt agrees with raw status and enable
    a_r6_irq_combine: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == ((raw_st & en_q) != '0));

    // R3: level-sensed lines track the pin against polarity
    a_r3_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_st & mode_q) == (mode_q & ~(pin_in ^ pol_q)));

    // R9: a new edge status bit needs a pin transition on the previous edge
    a_r9_edge_needs_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 &&
         (raw_st & ~$past(raw_st) & ~mode_q & ~$past(mode_q)) != '0)
        |-> ($past(pin_in) != $past(pin_in, 2)));

    // R7: a clear with no competing transition empties the edge bit
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3)
        |-> ((raw_st & $past(clr_pulse) & ~mode_q & ~$past(mode_q)
              & ~($past(pin_in) ^ $past(pin_in, 2))) == '0));

    // R7: the clear offset reads as zero
    a_r7_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFF_CLEAR)) |-> bus_rdata == '0);

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .irq_out   (irq_out),
    .mode_q    (mode_q),
    .pol_q     (pol_q),
    .en_q      (en_q),
    .raw_st    (raw_st),
    .clr_pulse (clr_pulse)
);

// File: tb/gpio_irq_detect_test.sv
// Bench for gpio_irq_detect: sweeps every mode over every line and adds
// directed cases for reset, readback, ignored writes and the clear race.
module gpio_irq_detect_test;

    localparam int N = 8;
    localparam int AW = 12;
    localparam logic [11:0] A_MODE = 12'h404, A_ANY = 12'h408, A_POL = 12'h40C,
                            A_EN = 12'h410, A_RAW = 12'h414, A_MSK = 12'h418,
                            A_CLR = 12'h41C, A_GAP = 12'h400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_in = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic          irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_detect #(.NUM_LINES(N), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        @(negedge clk);
        pin_in = v;
        @(negedge clk);
    endtask

    // Mode codes: 0 level high, 1 level low, 2 rising, 3 falling, 4 any edge
    task automatic run_mode(input int ln, input int m);
        logic [N-1:0] b, v;
        logic e;
        b = N'(1) << ln;
        wr(A_MODE, (m < 2) ? b : '0);
        wr(A_ANY,  (m == 4) ? b : '0);
        wr(A_POL,  (m == 0 || m == 2) ? b : '0);
        wr(A_EN, b);
        set_pins('0);
        wr(A_CLR, '1);
        rd(A_RAW, v);
        chk("R3 idle low", v, (m == 1) ? b : '0);
        set_pins(b);
        rd(A_RAW, v);
        e = (m == 0 || m == 2 || m == 4);
        chk("R4/R5 after rise", v, e ? b : '0);
        chk("R6 irq after rise", {{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, e});
        wr(A_CLR, b);
        rd(A_RAW, v);
        chk("R7/R3 after clear", v, (m == 0) ? b : '0);
        set_pins('0);
        rd(A_RAW, v);
        e = (m == 1 || m == 3 || m == 4);
        chk("R4/R5 after fall", v, e ? b : '0);
        rd(A_MSK, v);
        chk("R6 masked", v, e ? b : '0);
        wr(A_EN, '0);
        rd(A_MSK, v);
        chk("R6 masked when disabled", v, '0);
        chk("R6 irq when disabled", {{(N-1){1'b0}}, irq_out}, '0);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] v;
        pin_in = '1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state, R9 no hit on first sample (pins high since reset)
        rd(A_MODE, v); chk("R1 mode", v, '0);
        rd(A_ANY, v);  chk("R1 anyedge", v, '0);
        rd(A_POL, v);  chk("R1 polarity", v, '0);
        rd(A_EN, v);   chk("R1 enable", v, '0);
        rd(A_RAW, v);  chk("R1/R9 raw", v, '0);
        rd(A_MSK, v);  chk("R1 masked", v, '0);
        chk("R1 irq", {{(N-1){1'b0}}, irq_out}, '0);
        // R2 readback
        wr(A_MODE, 8'hA5); wr(A_ANY, 8'h3C); wr(A_POL, 8'h96); wr(A_EN, 8'h0F);
        rd(A_MODE, v); chk("R2 mode", v, 8'hA5);
        rd(A_ANY, v);  chk("R2 anyedge", v, 8'h3C);
        rd(A_POL, v);  chk("R2 polarity", v, 8'h96);
        rd(A_EN, v);   chk("R2 enable", v, 8'h0F);
        // R10 writes to read-only and unmapped offsets ignored
        wr(A_MODE, '0); wr(A_ANY, '0); wr(A_POL, '0); wr(A_EN, '1);
        wr(A_RAW, '1); wr(A_MSK, '1); wr(A_GAP, 8'h3C);
        rd(A_RAW, v);  chk("R10 raw untouched", v, '0);
        rd(A_MSK, v);  chk("R10 masked untouched", v, '0);
        rd(A_GAP, v);  chk("R10 unmapped reads zero", v, '0);
        rd(A_MODE, v); chk("R10 mode untouched", v, '0);
        rd(A_EN, v);   chk("R10 enable untouched", v, '1);
        rd(A_CLR, v);  chk("R7 clear reads zero", v, '0);
        // Sweep every mode over every line
        for (int ln = 0; ln < N; ln++)
            for (int m = 0; m < 5; m++)
                run_mode(ln, m);
        // R8 hit and clear on the same edge: hit wins
        wr(A_MODE, '0); wr(A_ANY, '0); wr(A_POL, 8'h01); wr(A_EN, 8'h01);
        set_pins('0); wr(A_CLR, '1);
        @(negedge clk);
        pin_in = 8'h01;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 8'h01;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(A_RAW, v); chk("R8 hit beats clear", v, 8'h01);
        chk("R8 irq", {{(N-1){1'b0}}, irq_out}, 8'h01);
        // R7 writing zero to clear changes nothing
        wr(A_CLR, 8'h00);
        rd(A_RAW, v); chk("R7 zero write keeps", v, 8'h01);
        // R9 rewriting configuration with still pins makes no hit
        wr(A_CLR, '1);
        set_pins(8'hF0);
        wr(A_CLR, '1);
        wr(A_POL, 8'h00); wr(A_ANY, 8'hFF); wr(A_POL, 8'hFF); wr(A_ANY, 8'h00);
        wr(A_MODE, 8'hFF); wr(A_MODE, 8'h00);
        rd(A_RAW, v); chk("R9 no false hit", v, '0);
        // R3 level mode not clearable, R6 multi-line combine
        wr(A_MODE, 8'hFF); wr(A_POL, 8'hCC); wr(A_EN, 8'h0F);
        wr(A_CLR, '1);
        rd(A_RAW, v); chk("R3 level vs pins", v, ~(8'hF0 ^ 8'hCC));
        rd(A_MSK, v); chk("R6 masked multi", v, ~(8'hF0 ^ 8'hCC) & 8'h0F);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule